// File: doc/BRIEF.md
# Rounding Shift-Right Accumulate Vector Unit

This block is one lane-parallel datapath step of a vector pipeline. It takes an accumulator vector, a source vector and an immediate shift count. Every lane shifts its source right with round-to-nearest and adds the result to the matching accumulator lane. The vector is 128 bits wide, or 64 bits wide when the wide flag is low. Lanes are 8, 16, 32 or 64 bits wide and are treated as either signed or unsigned.

The rounding constant is added one bit above the lane width, so it never wraps. A shift equal to the whole lane width is legal and gives a defined result. The final accumulate wraps modulo the lane width and has no saturation.

A transaction is accepted when `in_valid` and `in_ready` are both high. The result sits in a single output register and is presented one cycle later. A shift count outside the legal range is flagged. In that case the accumulator passes through unchanged.

Top module: `rsra_unit`

## Requirements
- R1: For a signed lane of width W and shift n, the lane result is acc + floor((src + 2^(n-1)) / 2^n), with src read as two's complement and the sum wrapped modulo 2^W; for example acc 0xF0, src 0x11, n=1 on byte lanes gives 0xF9.
- R2: For an unsigned lane the same formula holds with src read as an unsigned number (logical shift).
- R3: The rounding addition never wraps: with a zero accumulator, a signed maximum source gives 0x40 at n=1 and 0x10 at n=3 in byte lanes (0x4000/0x1000 in 16-bit lanes), and an unsigned maximum source gives 0x80 at n=1 and 0x20 at n=3.
- R4: A shift equal to the lane width is legal: a signed maximum or minimum source then contributes 0, and an unsigned maximum source contributes 1. A signed minimum source contributes 0xC0 at n=1 and 0xF0 at n=3 in byte lanes.
- R5: `lane_sz` selects the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Lane k occupies bits [k*W +: W], and no carry crosses a lane boundary.
- R6: When `wide` is 0, only bits [63:0] are processed and bits [127:64] of the result are 0.
- R7: A shift of 0 or a shift greater than the lane width sets `err_o` with the result. The result is then the accumulator, masked as in R6. A legal shift clears `err_o`.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An accepted transaction appears on `res_o` with `out_valid` high after the next rising edge. The output is held stable while `out_valid` is high and `out_ready` is low.
- R9: After reset, `out_valid`, `res_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are present |
| in_ready | output | 1 | Unit can take operands this cycle |
| lane_sz | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| is_signed | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| wide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| shift_amt | input | 7 | Right-shift count, legal range 1..lane width |
| acc_i | input | 128 | Accumulator vector |
| src_i | input | 128 | Source vector to be shifted |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| res_o | output | 128 | Result vector |
| err_o | output | 1 | The result came from an illegal shift count |

## Verification
The bench aims at the extreme sources: signed maximum, signed minimum and unsigned all-ones, with shifts of 1, 3 and the full lane width. A datapath only W bits wide would wrap the rounding add in these cases, returning 0 or a negative value instead of 0x80, 0x40 or 1. Random mixes of lane width and sign catch a carry or a sign bit leaking across a lane boundary. They also catch a logical shift used where an arithmetic one belongs, which turns negative contributions into large positive ones. Shifts of 0 and of lane width plus one would otherwise yield garbage or a stale error flag. A stalled consumer would expose a result register that updates under backpressure.

// File: rtl/rsra_pkg.sv
package rsra_pkg;

  localparam int SH_W = 7;

  typedef enum logic [1:0] {
    LSZ_8  = 2'd0,
    LSZ_16 = 2'd1,
    LSZ_32 = 2'd2,
    LSZ_64 = 2'd3
  } lane_sz_e;

  // lane width in bits for a size code
  function automatic int unsigned lane_bits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction

  // a shift count is usable when it lies in 1..lane width
  function automatic logic shift_in_range(input logic [1:0] code, input logic [SH_W-1:0] sh);
    int unsigned w;
    w = lane_bits(code);
    return (sh != '0) && (32'(sh) <= w);
  endfunction

endpackage

// File: rtl/rsra_lane.sv
module rsra_lane #(
  parameter int W    = 8,
  parameter int SH_W = 7
) (
  input  logic [W-1:0]    acc_i,
  input  logic [W-1:0]    src_i,
  input  logic            sgn_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [W-1:0]    res_o
);
  localparam int XW = W + 1;

  // source widened by one bit, rounded, shifted, then accumulated with wrap
  function automatic logic [W-1:0] round_shift_acc(
    input logic [W-1:0]    acc,
    input logic [W-1:0]    src,
    input logic            sgn,
    input logic [SH_W-1:0] sh
  );
    logic [XW-1:0] ext;
    logic [XW-1:0] bias;
    logic [XW-1:0] tot;
    logic [XW-1:0] shr;
    ext  = {sgn & src[W-1], src};
    bias = XW'(1) << (sh - SH_W'(1));
    tot  = ext + bias;
    if (sgn) shr = XW'($signed(tot) >>> sh);
    else     shr = tot >> sh;
    return W'(XW'(acc) + shr);
  endfunction

  assign res_o = round_shift_acc(acc_i, src_i, sgn_i, sh_i);

endmodule

// File: rtl/rsra_shift_chk.sv
module rsra_shift_chk
  import rsra_pkg::*;
(
  input  logic [1:0]      lane_sz,
  input  logic [SH_W-1:0] shift_amt,
  output logic            shift_ok
);
  assign shift_ok = shift_in_range(lane_sz, shift_amt);
endmodule

// File: rtl/rsra_unit.sv
module rsra_unit
  import rsra_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       lane_sz,
  input  logic             is_signed,
  input  logic             wide,
  input  logic [SH_W-1:0]  shift_amt,
  input  logic [VEC_W-1:0] acc_i,
  input  logic [VEC_W-1:0] src_i,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] res_o,
  output logic             err_o
);
  localparam int HALF_W = VEC_W / 2;
  localparam int N_SZ   = 4;

  logic [VEC_W-1:0] size_res [N_SZ];
  logic [VEC_W-1:0] lane_out;
  logic [VEC_W-1:0] next_res;
  logic             shift_ok;
  logic             accept;
  logic [VEC_W-1:0] res_q;
  logic             err_q;
  logic             vld_q;

  // one bank of lanes per lane width; the size code picks the bank
  for (genvar g = 0; g < N_SZ; g++) begin : g_size
    localparam int W = 8 << g;
    localparam int N = VEC_W / W;
    for (genvar i = 0; i < N; i++) begin : g_lane
      rsra_lane #(.W(W), .SH_W(SH_W)) u_lane (
        .acc_i (acc_i[i*W +: W]),
        .src_i (src_i[i*W +: W]),
        .sgn_i (is_signed),
        .sh_i  (shift_amt),
        .res_o (size_res[g][i*W +: W])
      );
    end
  end

  rsra_shift_chk u_shchk (
    .lane_sz   (lane_sz),
    .shift_amt (shift_amt),
    .shift_ok  (shift_ok)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    lane_out = size_res[lane_sz];
    next_res = shift_ok ? lane_out : acc_i;
    if (!wide) next_res[VEC_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      err_q <= 1'b0;
    end else if (accept) begin
      vld_q <= 1'b1;
      res_q <= next_res;
      err_q <= !shift_ok;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign res_o     = res_q;
  assign err_o     = err_q;

endmodule

// File: rtl/rsra_unit_chk.sv
module rsra_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             in_ready,
  input logic [1:0]       lane_sz,
  input logic             wide,
  input logic [6:0]       shift_amt,
  input logic [VEC_W-1:0] acc_i,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] res_o,
  input logic             err_o
);
  localparam int HALF_W = VEC_W / 2;

  logic [7:0]       width_c;
  logic             bad_shift;
  logic [VEC_W-1:0] acc_masked;

  always_comb begin
    case (lane_sz)
      2'd0:    width_c = 8'd8;
      2'd1:    width_c = 8'd16;
      2'd2:    width_c = 8'd32;
      default: width_c = 8'd64;
    endcase
    bad_shift  = (shift_amt == 7'd0) || ({1'b0, shift_amt} > width_c);
    acc_masked = acc_i;
    if (!wide) acc_masked[VEC_W-1:HALF_W] = '0;
  end

  p_accept_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_o) && $stable(err_o)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_bad_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_shift) |=> (err_o && res_o == $past(acc_masked)));

  p_good_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bad_shift) |=> !err_o);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wide) |=> (res_o[VEC_W-1:HALF_W] == '0));

endmodule

bind rsra_unit rsra_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .in_ready  (in_ready),
  .lane_sz   (lane_sz),
  .wide      (wide),
  .shift_amt (shift_amt),
  .acc_i     (acc_i),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .res_o     (res_o),
  .err_o     (err_o)
);

// File: tb/rsra_unit_bench.sv
module rsra_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   lane_sz = '0;
  logic         is_signed = 1'b0;
  logic         wide = 1'b1;
  logic [6:0]   shift_amt = 7'd1;
  logic [127:0] acc_i = '0;
  logic [127:0] src_i = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] res_o;
  logic         err_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;  // 125 MHz

  rsra_unit u_rsra_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .lane_sz(lane_sz), .is_signed(is_signed), .wide(wide), .shift_amt(shift_amt),
    .acc_i(acc_i), .src_i(src_i), .out_valid(out_valid), .out_ready(out_ready),
    .res_o(res_o), .err_o(err_o)
  );

  function automatic bit ref_bad(input logic [1:0] sz, input logic [6:0] sh);
    int w;
    w = 8 * (1 << sz);
    return (sh == 0) || (int'(sh) > w);
  endfunction

  // reference: exact integer value, add half step, floor-divide, wrap into lane
  function automatic logic [127:0] ref_res(input logic [127:0] acc, input logic [127:0] src,
                                           input logic [1:0] sz, input bit sgn,
                                           input logic [6:0] sh, input bit wd);
    logic [127:0] r;
    int w;
    w = 8 * (1 << sz);
    if (ref_bad(sz, sh)) begin
      r = acc;
    end else begin
      r = '0;
      for (int k = 0; k < 128 / w; k++) begin
        logic [63:0] a;
        logic [63:0] s;
        logic signed [70:0] v;
        logic signed [70:0] q;
        logic [63:0] sum;
        a = '0;
        s = '0;
        for (int b = 0; b < w; b++) begin
          a[b] = acc[k*w + b];
          s[b] = src[k*w + b];
        end
        v = $signed({7'd0, s});
        if (sgn && s[w-1]) v = v - (71'sd1 <<< w);
        q = (v + (71'sd1 <<< (sh - 1))) >>> sh;
        sum = a + q[63:0];
        for (int b = 0; b < w; b++) r[k*w + b] = sum[b];
      end
    end
    if (!wd) r[127:64] = '0;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] fill(input logic [63:0] v, input logic [1:0] sz);
    logic [127:0] r;
    int w;
    w = 8 * (1 << sz);
    r = '0;
    for (int k = 0; k < 128 / w; k++)
      for (int b = 0; b < w; b++) r[k*w + b] = v[b];
    return r;
  endfunction

  // one transaction with the consumer always ready; result checked after the edge
  task automatic run(input logic [127:0] a, input logic [127:0] s, input logic [1:0] sz,
                     input bit sg, input logic [6:0] sh, input bit wd, input string req);
    logic [127:0] exp;
    bit eerr;
    @(negedge clk);
    acc_i = a; src_i = s; lane_sz = sz; is_signed = sg; shift_amt = sh; wide = wd;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp  = ref_res(a, s, sz, sg, sh, wd);
    eerr = ref_bad(sz, sh);
    check(out_valid && res_o == exp && err_o == eerr, req, res_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] e;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R9 reset state
    check(!out_valid && res_o == '0 && !err_o, "R9", res_o, 128'd0);
    rst_n = 1'b1;

    // R1 worked example on byte lanes
    run(fill(64'hF0, 0), fill(64'h11, 0), 2'd0, 1'b1, 7'd1, 1'b1, "R1");
    check(res_o == fill(64'hF9, 0), "R1 example", res_o, fill(64'hF9, 0));
    // R3 no wrap of the rounding add
    run('0, fill(64'h7F, 0), 2'd0, 1'b1, 7'd1, 1'b1, "R3");
    check(res_o == fill(64'h40, 0), "R3 s8 sh1", res_o, fill(64'h40, 0));
    run('0, fill(64'hFF, 0), 2'd0, 1'b0, 7'd1, 1'b1, "R3");
    check(res_o == fill(64'h80, 0), "R3 u8 sh1", res_o, fill(64'h80, 0));
    run('0, fill(64'hFF, 0), 2'd0, 1'b0, 7'd3, 1'b1, "R3");
    check(res_o == fill(64'h20, 0), "R3 u8 sh3", res_o, fill(64'h20, 0));
    run('0, fill(64'h7FFF, 1), 2'd1, 1'b1, 7'd3, 1'b1, "R3");
    check(res_o == fill(64'h1000, 1), "R3 s16 sh3", res_o, fill(64'h1000, 1));
    // R4 full-width shift and minimum input
    run('0, fill(64'hFFFF_FFFF_FFFF_FFFF, 3), 2'd3, 1'b0, 7'd64, 1'b1, "R4");
    check(res_o == fill(64'd1, 3), "R4 u64 shmax", res_o, fill(64'd1, 3));
    run('0, fill(64'h8000_0000_0000_0000, 3), 2'd3, 1'b1, 7'd64, 1'b1, "R4");
    check(res_o == '0, "R4 s64 min shmax", res_o, '0);
    run('0, fill(64'h7FFF_FFFF, 2), 2'd2, 1'b1, 7'd32, 1'b1, "R4");
    check(res_o == '0, "R4 s32 max shmax", res_o, '0);
    run('0, fill(64'h80, 0), 2'd0, 1'b1, 7'd1, 1'b1, "R4");
    check(res_o == fill(64'hC0, 0), "R4 s8 min sh1", res_o, fill(64'hC0, 0));
    run('0, fill(64'h80, 0), 2'd0, 1'b1, 7'd3, 1'b1, "R4");
    check(res_o == fill(64'hF0, 0), "R4 s8 min sh3", res_o, fill(64'hF0, 0));
    // R2 unsigned lanes and R5 independent lanes
    run(fill(64'hFFFF_FFF0, 2), fill(64'h77, 2), 2'd2, 1'b0, 7'd5, 1'b1, "R2");
    run({64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 2'd3, 1'b0, 7'd1, 1'b1, "R5");
    check(res_o[127:64] == '0, "R5 no carry into next lane", res_o, {64'h0, 64'h7FFF_FFFF_FFFF_FFFF});
    // R6 narrow vector
    run({128{1'b1}}, {128{1'b1}}, 2'd1, 1'b0, 7'd2, 1'b0, "R6");
    check(res_o[127:64] == '0, "R6 upper zero", res_o, '0);
    // R7 illegal shifts
    run(fill(64'h5A, 0), fill(64'h33, 0), 2'd0, 1'b1, 7'd0, 1'b1, "R7");
    run(fill(64'h1234, 1), fill(64'h33, 1), 2'd1, 1'b0, 7'd17, 1'b0, "R7");
    e = ref_res(fill(64'h1234, 1), '0, 2'd1, 1'b0, 7'd17, 1'b0);
    check(err_o && res_o == e, "R7 passthrough", res_o, e);

    // R8 backpressure: result held, second operand set waits
    @(negedge clk);
    acc_i = fill(64'h01, 0); src_i = fill(64'h10, 0); lane_sz = 2'd0; is_signed = 1'b0;
    shift_amt = 7'd4; wide = 1'b1; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    e = fill(64'h02, 0);
    check(out_valid && res_o == e && !in_ready, "R8 load under stall", res_o, e);
    acc_i = fill(64'h03, 0);
    @(negedge clk);
    check(out_valid && res_o == e && !in_ready, "R8 hold", res_o, e);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = fill(64'h04, 0);
    check(out_valid && res_o == e && !err_o, "R8 resume", res_o, e);
    @(negedge clk);
    check(!out_valid && in_ready, "R8 drain", {127'd0, out_valid}, 128'd0);

    // random mix: R1 R2 R5 R6 R7
    for (int t = 0; t < 400; t++) begin
      logic [1:0] sz;
      logic [6:0] sh;
      bit sg;
      int w;
      sz = 2'($urandom_range(0, 3));
      sg = 1'($urandom_range(0, 1));
      w  = 8 * (1 << sz);
      if ($urandom_range(0, 9) == 0) sh = ($urandom_range(0, 1) == 0) ? 7'd0 : 7'($urandom_range(w + 1, 127));
      else sh = 7'($urandom_range(1, w));
      run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
          sz, sg, sh, 1'($urandom_range(0, 1)), sg ? "R1 random" : "R2 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule